// File: doc/BRIEF.md
# DVMA Page-Table Translation Unit

This unit turns a 32-bit device virtual address into a physical address. It walks a single-level page table that sits in system memory. A request is taken on a valid/ready input. The unit takes the table base and the window start from plain control inputs and forms the address of the 4-byte table entry. It issues one 32-bit read on a request/response memory port. When the entry arrives, the unit forms the physical address from the entry's page number and the 12-bit page offset, and it reports fault and cacheable flags on a valid/ready result channel. Only one walk runs at a time. While a walk is in flight the unit is busy and refuses new requests.

All three streams follow the usual valid/ready rules. A transfer happens on a clock edge where both valid and ready are high. Once valid is raised, the payload holds still and valid stays high until the transfer happens. The unit raises `mem_req_valid` and `res_valid` only in this way. It expects its neighbours to treat `req_valid` and `mem_rsp_valid` the same way. `mem_rsp_ready` is high only after the read request has been taken, so a response that arrives early is held back. When translation is switched off, the virtual address goes straight to the result and no memory read is made.

Top module: `dvma_xlate_top`

## Requirements
- R1: After reset `req_ready` is 1. `busy`, `mem_req_valid`, `mem_rsp_ready` and `res_valid` are all 0.
- R2: With translation enabled, an accepted request produces exactly one memory read. Its address is `(tbl_base << 4) + (((req_vaddr & ~win_start) >> 10) & ~3)`, 32 bits wide, computed from the `tbl_base` and `win_start` values present on the accepting clock edge. Later changes to those inputs do not alter it.
- R3: With `SWAP_BYTES`=1 the entry is stored big-endian, and the port delivers its bytes in reverse order: entry bits [7:0] arrive on `mem_rsp_data[31:24]`, and so on.
- R4: For a valid entry with no fault, `res_paddr` = {1'b0, entry[26:8], vaddr[11:0]}. Entry bits [31:27], [6:3] and [0] have no effect on it.
- R5: An entry with bit 1 (valid) clear gives `res_fault_inv`=1, `res_fault_prot`=0, `res_cacheable`=0 and `res_paddr`=0.
- R6: A write request (`req_write`=1) to a valid entry with bit 2 (writeable) clear gives `res_fault_prot`=1 and `res_paddr`=0. A read of the same entry completes without fault.
- R7: `res_cacheable` equals entry bit 7 for a result without fault.
- R8: With `xlate_en`=0 on the accepting edge, `res_valid` rises on the next cycle with `res_paddr` = `req_vaddr` and no fault flags. No memory request is issued.
- R9: From acceptance until the result is taken, `busy` is 1 and `req_ready` is 0, so a request offered during that time is not taken.
- R10: Under back-pressure, `mem_req_valid` and `mem_req_addr` hold until `mem_req_ready` is high. `res_valid` and the result fields hold until `res_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlate_en | input | 1 | Translation enable |
| tbl_base | input | 32 | Page table base (shifted left by 4 to form a byte address) |
| win_start | input | 32 | Window start; its set bits are stripped from the virtual address |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_vaddr | input | 32 | Device virtual address |
| req_write | input | 1 | Request is a write access |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Unit accepts read data |
| mem_rsp_data | input | 32 | Entry word as seen on the port |
| res_valid | output | 1 | Translation result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_paddr | output | 32 | Physical address (0 on a fault) |
| res_fault_inv | output | 1 | Entry was not valid |
| res_fault_prot | output | 1 | Write to an entry that is not writeable |
| res_cacheable | output | 1 | Entry marks the page cacheable |
| busy | output | 1 | A walk is in flight |

## Verification
The assertions assume that the memory side never returns data before its read has been taken. They also assume `mem_rsp_valid` is raised only while the unit waits for it. The bench's memory model answers strictly after the request handshake and drops its response valid right after the transfer. The assertions also assume the result consumer only lowers `res_ready` between transfers. The bench holds `res_ready` low for a set number of cycles and raises it once, for a single edge, per result. Requests are offered only while `req_ready` is seen high, except in the deliberate busy test. There the bench keeps `req_valid` up with a decoy address and drops it before the unit returns to idle.

// File: rtl/dvma_pkg.sv
package dvma_pkg;

  localparam int ADDR_W = 32;
  localparam int PTE_W  = 32;

  // Entry bit positions consumed by the decoder
  localparam int PTE_CACHE_B = 7;
  localparam int PTE_WR_B    = 2;
  localparam int PTE_VLD_B   = 1;

  typedef enum logic [1:0] {
    WS_IDLE     = 2'd0,
    WS_WAIT_PTE = 2'd1,
    WS_DONE     = 2'd2
  } walk_st_e;

  typedef struct packed {
    logic [ADDR_W-1:0] paddr;
    logic              f_inv;
    logic              f_prot;
    logic              cache;
  } xlate_res_t;

endpackage

// File: rtl/dvma_ent_addr.sv
module dvma_ent_addr
  import dvma_pkg::*;
#(
  parameter int PAGE_SHIFT = 12,
  parameter int BASE_SHIFT = 4
) (
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [ADDR_W-1:0] win_start,
  input  logic [ADDR_W-1:0] vaddr,
  output logic [ADDR_W-1:0] ent_addr
);

  // One 4-byte entry per page: page index scaled by 4
  localparam int IDX_SHIFT = PAGE_SHIFT - 2;
  localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(3);

  logic [ADDR_W-1:0] in_window;
  logic [ADDR_W-1:0] scaled_idx;
  logic [ADDR_W-1:0] base_byte;

  always_comb begin
    in_window  = vaddr & ~win_start;
    scaled_idx = (in_window >> IDX_SHIFT) & WORD_MASK;
    base_byte  = tbl_base << BASE_SHIFT;
    ent_addr   = base_byte + scaled_idx;
  end

endmodule

// File: rtl/dvma_pte_dec.sv
module dvma_pte_dec
  import dvma_pkg::*;
#(
  parameter int PAGE_SHIFT = 12,
  parameter int PPN_LO     = 8,
  parameter int PPN_HI     = 26,
  parameter bit SWAP_BYTES = 1'b1
) (
  input  logic [PTE_W-1:0]      port_word,
  input  logic [PAGE_SHIFT-1:0] page_off,
  input  logic                  is_write,
  output xlate_res_t            res
);

  localparam int NBYTES = PTE_W / 8;
  localparam int PPN_W  = PPN_HI - PPN_LO + 1;
  localparam int PAD_W  = ADDR_W - PPN_W - PAGE_SHIFT;

  logic [PTE_W-1:0]  pte;
  logic [ADDR_W-1:0] good_pa;
  logic              vld, wr_ok, prot_hit;
  logic              unused_pte;

  // Byte order of the port relative to the stored entry
  if (SWAP_BYTES) begin : g_swap
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assign pte[8*b +: 8] = port_word[8*(NBYTES-1-b) +: 8];
    end
  end else begin : g_noswap
    assign pte = port_word;
  end

  if (PAD_W > 0) begin : g_pad
    assign good_pa = {{PAD_W{1'b0}}, pte[PPN_HI:PPN_LO], page_off};
  end else begin : g_nopad
    assign good_pa = {pte[PPN_HI:PPN_LO], page_off};
  end

  assign unused_pte = ^pte;

  always_comb begin
    vld      = pte[PTE_VLD_B];
    wr_ok    = pte[PTE_WR_B];
    prot_hit = vld && is_write && !wr_ok;
    res        = '0;
    res.f_inv  = !vld;
    res.f_prot = prot_hit;
    if (vld && !prot_hit) begin
      res.paddr = good_pa;
      res.cache = pte[PTE_CACHE_B];
    end
  end

endmodule

// File: rtl/dvma_walk_ctl.sv
module dvma_walk_ctl
  import dvma_pkg::*;
#(
  parameter int PAGE_SHIFT = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  xlate_en,
  input  logic                  req_valid,
  input  logic [ADDR_W-1:0]     req_vaddr,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     ent_addr,
  input  logic                  mem_req_ready,
  input  logic                  mem_rsp_valid,
  input  logic                  res_ready,
  input  xlate_res_t            dec_res,
  output logic                  req_ready,
  output logic                  mem_req_valid,
  output logic [ADDR_W-1:0]     mem_req_addr,
  output logic                  mem_rsp_ready,
  output logic                  res_valid,
  output xlate_res_t            res_q,
  output logic [PAGE_SHIFT-1:0] off_q,
  output logic                  wr_q,
  output logic                  busy
);

  walk_st_e          st_q, st_d;
  logic              pend_q;
  logic [ADDR_W-1:0] addr_q;
  logic              take_req, take_rsp;

  assign req_ready     = (st_q == WS_IDLE);
  assign busy          = (st_q != WS_IDLE);
  assign mem_req_valid = (st_q == WS_WAIT_PTE) && pend_q;
  assign mem_rsp_ready = (st_q == WS_WAIT_PTE) && !pend_q;
  assign res_valid     = (st_q == WS_DONE);
  assign mem_req_addr  = addr_q;

  assign take_req = req_ready && req_valid;
  assign take_rsp = mem_rsp_ready && mem_rsp_valid;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      WS_IDLE:     if (take_req) st_d = xlate_en ? WS_WAIT_PTE : WS_DONE;
      WS_WAIT_PTE: if (take_rsp) st_d = WS_DONE;
      WS_DONE:     if (res_ready) st_d = WS_IDLE;
      default:     st_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= WS_IDLE;
      pend_q <= 1'b0;
      addr_q <= '0;
      off_q  <= '0;
      wr_q   <= 1'b0;
      res_q  <= '0;
    end else begin
      st_q <= st_d;
      if (take_req) begin
        off_q <= req_vaddr[PAGE_SHIFT-1:0];
        wr_q  <= req_write;
        if (xlate_en) begin
          addr_q <= ent_addr;
          pend_q <= 1'b1;
        end else begin
          res_q       <= '0;
          res_q.paddr <= req_vaddr;
        end
      end
      if (mem_req_valid && mem_req_ready) pend_q <= 1'b0;
      if (take_rsp) res_q <= dec_res;
    end
  end

endmodule

// File: rtl/dvma_xlate_top.sv
module dvma_xlate_top
  import dvma_pkg::*;
#(
  parameter int PAGE_SHIFT = 12,
  parameter int BASE_SHIFT = 4,
  parameter int PPN_LO     = 8,
  parameter int PPN_HI     = 26,
  parameter bit SWAP_BYTES = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xlate_en,
  input  logic [31:0] tbl_base,
  input  logic [31:0] win_start,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  output logic        mem_rsp_ready,
  input  logic [31:0] mem_rsp_data,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [31:0] res_paddr,
  output logic        res_fault_inv,
  output logic        res_fault_prot,
  output logic        res_cacheable,
  output logic        busy
);

  logic [ADDR_W-1:0]     ent_addr;
  xlate_res_t            dec_res, res_q;
  logic [PAGE_SHIFT-1:0] off_q;
  logic                  wr_q;

  dvma_ent_addr #(
    .PAGE_SHIFT (PAGE_SHIFT),
    .BASE_SHIFT (BASE_SHIFT)
  ) u_ent (
    .tbl_base  (tbl_base),
    .win_start (win_start),
    .vaddr     (req_vaddr),
    .ent_addr  (ent_addr)
  );

  dvma_pte_dec #(
    .PAGE_SHIFT (PAGE_SHIFT),
    .PPN_LO     (PPN_LO),
    .PPN_HI     (PPN_HI),
    .SWAP_BYTES (SWAP_BYTES)
  ) u_dec (
    .port_word (mem_rsp_data),
    .page_off  (off_q),
    .is_write  (wr_q),
    .res       (dec_res)
  );

  dvma_walk_ctl #(
    .PAGE_SHIFT (PAGE_SHIFT)
  ) u_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .xlate_en      (xlate_en),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .req_write     (req_write),
    .ent_addr      (ent_addr),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .res_ready     (res_ready),
    .dec_res       (dec_res),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_ready (mem_rsp_ready),
    .res_valid     (res_valid),
    .res_q         (res_q),
    .off_q         (off_q),
    .wr_q          (wr_q),
    .busy          (busy)
  );

  assign res_paddr      = res_q.paddr;
  assign res_fault_inv  = res_q.f_inv;
  assign res_fault_prot = res_q.f_prot;
  assign res_cacheable  = res_q.cache;

endmodule

// File: rtl/dvma_xlate_chk.sv
module dvma_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        xlate_en,
  input logic        req_valid,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        mem_rsp_ready,
  input logic        res_valid,
  input logic        res_ready,
  input logic [31:0] res_paddr,
  input logic        res_fault_inv,
  input logic        res_fault_prot,
  input logic        res_cacheable,
  input logic        busy
);

  // R9: no new request while a walk is in flight
  a_r9_busy_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // R10: read request holds under back-pressure
  a_r10_memreq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R10: result holds until taken
  a_r10_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_paddr)
      && $stable(res_fault_inv) && $stable(res_fault_prot) && $stable(res_cacheable)));

  // R8: disabled translation finishes next cycle with no memory read
  a_r8_bypass_next: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !xlate_en) |=> (res_valid && !mem_req_valid));

  // R2: enabled translation goes to a memory read
  a_r2_walk_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && xlate_en) |=> mem_req_valid);

  // R5/R6: fault kinds exclusive, and a faulted result has no address
  a_r5_fault_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (!(res_fault_inv && res_fault_prot)
      && (!(res_fault_inv || res_fault_prot) || (res_paddr == 32'd0))));

  // R1: handshake phases never overlap
  a_r1_phases_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, mem_req_valid, mem_rsp_ready, res_valid}));

endmodule

bind dvma_xlate_top dvma_xlate_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .xlate_en       (xlate_en),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .mem_req_valid  (mem_req_valid),
  .mem_req_ready  (mem_req_ready),
  .mem_req_addr   (mem_req_addr),
  .mem_rsp_ready  (mem_rsp_ready),
  .res_valid      (res_valid),
  .res_ready      (res_ready),
  .res_paddr      (res_paddr),
  .res_fault_inv  (res_fault_inv),
  .res_fault_prot (res_fault_prot),
  .res_cacheable  (res_cacheable),
  .busy           (busy)
);

// File: tb/dvma_xlate_top_tb_top.sv
module dvma_xlate_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xlate_en = 1'b0;
  logic [31:0] tbl_base = '0;
  logic [31:0] win_start = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [31:0] res_paddr;
  logic        res_fault_inv;
  logic        res_fault_prot;
  logic        res_cacheable;
  logic        busy;

  int n_vec  = 0;
  int n_miss = 0;
  int cyc    = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dvma_xlate_top dut_i (
    .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .tbl_base(tbl_base),
    .win_start(win_start), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_ready(res_ready),
    .res_paddr(res_paddr), .res_fault_inv(res_fault_inv),
    .res_fault_prot(res_fault_prot), .res_cacheable(res_cacheable), .busy(busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_miss++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] swap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [31:0] exp_ent(input logic [31:0] b, input logic [31:0] w,
                                          input logic [31:0] va);
    return (b << 4) + (((va & ~w) >> 10) & 32'hFFFF_FFFC);
  endfunction

  function automatic logic [31:0] exp_pa(input logic [31:0] pte, input logic [31:0] va);
    return ((pte & 32'h07FF_FF00) << 4) + (va & 32'h0000_0FFF);
  endfunction

  // One walk; results returned for the scenario task to check
  task automatic do_walk(
    input  logic [31:0] va, input logic wr, input logic [31:0] pte,
    input  int mstall, input int rstall, input bit hold_req, input bit chg_base,
    output logic [31:0] g_addr, output logic [31:0] g_pa,
    output logic g_inv, output logic g_prot, output logic g_cache, output bit saw_mem);
    logic [31:0] keep_base;
    int guard;
    keep_base = tbl_base;
    saw_mem = 1'b0;
    g_addr = '0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    @(posedge clk);
    @(negedge clk);
    if (hold_req) req_vaddr = 32'hCAFE_0000;
    else req_valid = 1'b0;
    if (chg_base) begin tbl_base = 32'h0BAD_0000; win_start = 32'h0; end
    if (xlate_en) begin
      guard = 0;
      while (!mem_req_valid && guard < 20) begin @(negedge clk); guard++; end
      saw_mem = mem_req_valid;
      g_addr = mem_req_addr;
      for (int i = 0; i < mstall; i++) begin
        @(negedge clk);
        chk("R10 mem_req held", {31'd0, mem_req_valid}, 32'd1);
        chk("R10 mem_req_addr stable", mem_req_addr, g_addr);
        if (hold_req) chk("R9 req_ready low while busy", {30'd0, req_ready, busy}, 32'd1);
      end
      mem_req_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b1;
      mem_rsp_data = swap32(pte);
      guard = 0;
      while (!mem_rsp_ready && guard < 20) begin @(negedge clk); guard++; end
      @(posedge clk);
      @(negedge clk);
      mem_rsp_valid = 1'b0;
    end
    guard = 0;
    while (!res_valid && guard < 20) begin
      if (mem_req_valid) saw_mem = 1'b1;
      @(negedge clk); guard++;
    end
    if (mem_req_valid) saw_mem = 1'b1;
    g_pa = res_paddr; g_inv = res_fault_inv; g_prot = res_fault_prot; g_cache = res_cacheable;
    for (int i = 0; i < rstall; i++) begin
      @(negedge clk);
      chk("R10 res held", {31'd0, res_valid}, 32'd1);
      chk("R10 res_paddr stable", res_paddr, g_pa);
      if (hold_req) chk("R9 req_ready low at result", {31'd0, req_ready}, 32'd0);
    end
    if (chg_base) tbl_base = keep_base;
    res_ready = 1'b1;
    req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    res_ready = 1'b0;
    chk("R9 idle after result taken", {30'd0, busy, req_ready}, 32'd1);
  endtask

  task automatic t_reset();
    chk("R1 reset req_ready", {31'd0, req_ready}, 32'd1);
    chk("R1 reset valids/busy",
        {28'd0, busy, mem_req_valid, mem_rsp_ready, res_valid}, 32'd0);
  endtask

  task automatic t_basic();
    logic [31:0] a, p, pte; logic fi, fp, c; bit sm;
    xlate_en = 1'b1; tbl_base = 32'h0010_0000; win_start = 32'hFF00_0000;
    pte = (32'h12345 << 8) | 32'h6;
    do_walk(32'hFF12_3ABC, 1'b0, pte, 0, 0, 0, 0, a, p, fi, fp, c, sm);
    chk("R2 one read issued", {31'd0, sm}, 32'd1);
    chk("R2 entry address", a, exp_ent(32'h0010_0000, 32'hFF00_0000, 32'hFF12_3ABC));
    chk("R3 R4 paddr via swapped word", p, 32'h1234_5ABC);
    chk("R4 paddr formula", p, exp_pa(pte, 32'hFF12_3ABC));
    chk("R4 no faults", {30'd0, fi, fp}, 32'd0);
  endtask

  task automatic t_ignored_bits_cache();
    logic [31:0] a, p, pte; logic fi, fp, c; bit sm;
    pte = 32'hF800_0000 | (32'h7FFFF << 8) | 32'h80 | 32'h78 | 32'h7;
    do_walk(32'hFF00_0FFF, 1'b1, pte, 0, 0, 0, 0, a, p, fi, fp, c, sm);
    chk("R4 spare entry bits ignored", p, 32'h7FFF_FFFF);
    chk("R7 cacheable set", {31'd0, c}, 32'd1);
    pte = (32'h00001 << 8) | 32'h2;
    do_walk(32'hFF00_1004, 1'b0, pte, 0, 0, 0, 0, a, p, fi, fp, c, sm);
    chk("R7 cacheable clear", {31'd0, c}, 32'd0);
    chk("R4 small page", p, 32'h0000_1004);
  endtask

  task automatic t_invalid();
    logic [31:0] a, p; logic fi, fp, c; bit sm;
    do_walk(32'hFF44_4123, 1'b0, (32'h55555 << 8) | 32'h85, 0, 0, 0, 0, a, p, fi, fp, c, sm);
    chk("R5 invalid fault", {29'd0, fi, fp, c}, 32'd4);
    chk("R5 invalid paddr zero", p, 32'd0);
  endtask

  task automatic t_protect();
    logic [31:0] a, p, pte; logic fi, fp, c; bit sm;
    pte = (32'h0ABCD << 8) | 32'h2;
    do_walk(32'hFF00_5010, 1'b1, pte, 0, 0, 0, 0, a, p, fi, fp, c, sm);
    chk("R6 write to read-only faults", {30'd0, fi, fp}, 32'd1);
    chk("R6 prot paddr zero", p, 32'd0);
    do_walk(32'hFF00_5010, 1'b0, pte, 0, 0, 0, 0, a, p, fi, fp, c, sm);
    chk("R6 read of read-only ok", {30'd0, fi, fp}, 32'd0);
    chk("R6 read paddr", p, 32'h0ABC_D010);
  endtask

  task automatic t_bypass();
    logic [31:0] a, p; logic fi, fp, c; bit sm;
    xlate_en = 1'b0;
    do_walk(32'h8765_4321, 1'b1, 32'h0, 0, 0, 0, 0, a, p, fi, fp, c, sm);
    chk("R8 no memory read", {31'd0, sm}, 32'd0);
    chk("R8 passthrough paddr", p, 32'h8765_4321);
    chk("R8 no faults", {29'd0, fi, fp, c}, 32'd0);
    xlate_en = 1'b1;
  endtask

  task automatic t_backpressure_busy();
    logic [31:0] a, p, pte; logic fi, fp, c; bit sm;
    pte = (32'h00777 << 8) | 32'h6;
    do_walk(32'hFF03_2A5A, 1'b0, pte, 3, 4, 1, 0, a, p, fi, fp, c, sm);
    chk("R10 addr after stall", a, exp_ent(32'h0010_0000, 32'hFF00_0000, 32'hFF03_2A5A));
    chk("R9 decoy not taken, paddr", p, 32'h0077_7A5A);
  endtask

  task automatic t_window_snapshot();
    logic [31:0] a, p, pte; logic fi, fp, c; bit sm;
    win_start = 32'h8000_0000; tbl_base = 32'h0002_0000;
    pte = (32'h40001 << 8) | 32'h2;
    do_walk(32'hF234_5678, 1'b0, pte, 1, 0, 0, 1, a, p, fi, fp, c, sm);
    chk("R2 wide window / base snapshot", a, exp_ent(32'h0002_0000, 32'h8000_0000, 32'hF234_5678));
    chk("R4 wide window paddr", p, 32'h4000_1678);
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        n_vec++; n_miss++;
        $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WATCHDOG);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_ignored_bits_cache();
    t_invalid();
    t_protect();
    t_bypass();
    t_backpressure_busy();
    t_window_snapshot();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

endmodule